// File: doc/BRIEF.md
# Integer Compare and Condition-Field Unit

This block is the condition-register side of a 32-bit integer execution path. It performs three kinds of operation. It compares two 32-bit values and records the outcome in one of eight 4-bit condition fields. It copies one condition field into another. It moves a 4-bit fixed-point exception status word into a field and clears that word in the same step. The compare can be signed or unsigned. Its second operand is either a full register value or a 16-bit immediate, and the immediate is extended according to the signedness of the compare.

Each operation arrives on a single-cycle valid strobe, with operands and decoded control presented together. The eight fields are stored as one 32-bit condition word, which is always visible on `cr_out`. The exception status word is always visible on `xs_out`. A separate load strobe lets the status bits be preset, so that summary-overflow, overflow and carry can be placed in a known state.

Top module: `cmp_crf_unit`

## Requirements
- R1: While reset is held, and after it is released, `cr_out` reads 0 and `xs_out` reads 0 until the first accepted operation or status load.
- R2: A compare (`op_kind` = 0) with `cmp_signed` = 1 and `use_imm` = 0 compares `opa` and `opb` as two's-complement numbers. It sets exactly one of bit 3 (less-than), bit 2 (greater-than) or bit 1 (equal) of the destination field.
- R3: With `cmp_signed` = 0 and `use_imm` = 0, the compare treats `opa` and `opb` as unsigned 32-bit numbers.
- R4: With `cmp_signed` = 1 and `use_imm` = 1, operand B is `imm16` sign-extended to 32 bits, and `opb` has no effect.
- R5: With `cmp_signed` = 0 and `use_imm` = 1, operand B is `imm16` zero-extended to 32 bits.
- R6: Bit 0 of a field written by a compare equals the summary-overflow status bit (`xs_out[3]`) as it stood when the compare was accepted.
- R7: Field k occupies `cr_out[31-4k : 28-4k]`, so field 0 is the top nibble. An operation writes only the field selected by `dst_fld`, and every other field keeps its value.
- R8: The result of an accepted operation appears on `cr_out` and `xs_out` one clock after the edge where `op_valid` is high. When `op_valid` is low, or `op_kind` = 3, neither output changes unless `xs_load` is high.
- R9: A field copy (`op_kind` = 1) writes the field selected by `src_fld`, as it stood before the edge, into the field selected by `dst_fld`.
- R10: A status move (`op_kind` = 2) writes `xs_out` (bit 3 summary-overflow, bit 2 overflow, bit 1 carry, bit 0 spare) into the destination field, in the same bit positions. It clears the status word to 0 on the same edge.
- R11: When `xs_load` is high, `xs_out` takes `xs_load_val` on the next clock. This load takes precedence over the clear of a status move accepted on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation strobe, one cycle per operation |
| op_kind | input | 2 | 0 compare, 1 field copy, 2 status move, 3 no operation |
| cmp_signed | input | 1 | 1 for a signed compare |
| use_imm | input | 1 | 1 selects the immediate as operand B |
| opa | input | 32 | Operand A |
| opb | input | 32 | Register operand B |
| imm16 | input | 16 | Immediate operand B |
| dst_fld | input | 3 | Destination field index |
| src_fld | input | 3 | Source field index for a copy |
| xs_load | input | 1 | Status word load strobe |
| xs_load_val | input | 4 | Value for the status word load |
| cr_out | output | 32 | Full condition word, field 0 in the top nibble |
| xs_out | output | 4 | Exception status word |

## Verification
The bound assertions check several rules on every cycle. A compare leaves exactly one outcome bit set, and its bit 0 matches the earlier summary-overflow bit. Fields other than the destination never move. A copy reproduces its source, and a status move leaves the status word cleared. Idle cycles change nothing, and a load lands one clock later. Only the directed scenarios can show that the outcome itself is right. That covers how signed and unsigned orderings differ at the sign boundary, how the immediate is extended, and which priority applies when a load meets a status move.

// File: rtl/cmpu_pkg.sv
package cmpu_pkg;
  localparam int XLEN    = 32;
  localparam int IMMW    = 16;
  localparam int NFIELDS = 8;
  localparam int FW      = 4;
  localparam int CRW     = NFIELDS * FW;
  localparam int IDXW    = $clog2(NFIELDS);

  typedef enum logic [1:0] {
    OPK_CMP   = 2'd0,
    OPK_COPY  = 2'd1,
    OPK_XMOVE = 2'd2,
    OPK_NONE  = 2'd3
  } opk_e;

  // positions inside one field
  localparam int BIT_LT = 3;
  localparam int BIT_GT = 2;
  localparam int BIT_EQ = 1;
  localparam int BIT_SO = 0;
  // summary-overflow position inside the status word
  localparam int XS_SO  = 3;
endpackage

// File: rtl/cmpu_rst_sync.sv
module cmpu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/cmpu_operand.sv
module cmpu_operand #(
  parameter int XLEN = 32,
  parameter int IMMW = 16
) (
  input  logic [XLEN-1:0] reg_b,
  input  logic [IMMW-1:0] imm,
  input  logic            use_imm,
  input  logic            is_signed,
  output logic [XLEN-1:0] b_eff
);
  localparam int PADW = XLEN - IMMW;
  logic [PADW-1:0] pad;

  always_comb begin
    pad   = is_signed ? {PADW{imm[IMMW-1]}} : '0;
    b_eff = use_imm ? {pad, imm} : reg_b;
  end
endmodule

// File: rtl/cmpu_compare.sv
module cmpu_compare #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic            is_signed,
  output logic [2:0]      res_lge
);
  logic a_lt, eq;
  logic msb_a, msb_b;
  logic lo_lt;

  always_comb begin
    msb_a = a[XLEN-1];
    msb_b = b[XLEN-1];
    lo_lt = a[XLEN-2:0] < b[XLEN-2:0];
    eq    = (a == b);
    if (msb_a != msb_b)
      a_lt = is_signed ? msb_a : msb_b;
    else
      a_lt = lo_lt;
    res_lge = {a_lt, !a_lt && !eq, eq};
  end
endmodule

// File: rtl/cmpu_field_file.sv
module cmpu_field_file #(
  parameter int NFIELDS = 8,
  parameter int FW      = 4,
  localparam int IDXW   = $clog2(NFIELDS),
  localparam int CRW    = NFIELDS * FW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [FW-1:0]   wr_data,
  input  logic [IDXW-1:0] rd_idx,
  output logic [FW-1:0]   rd_data,
  output logic [CRW-1:0]  cr_word
);
  logic [FW-1:0] fld_q [NFIELDS];

  for (genvar gi = 0; gi < NFIELDS; gi++) begin : g_fld
    logic fld_en;
    logic [FW-1:0] fld_d;

    always_comb begin
      fld_en = wr_en && (wr_idx == IDXW'(gi));
      fld_d  = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      fld_q[gi] <= '0;
      else if (fld_en) fld_q[gi] <= fld_d;
    end

    // field 0 lands in the top nibble
    assign cr_word[CRW-1-gi*FW -: FW] = fld_q[gi];
  end

  assign rd_data = fld_q[rd_idx];
endmodule

// File: rtl/cmpu_status.sv
module cmpu_status #(
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [SW-1:0] load_val,
  input  logic          clr,
  output logic [SW-1:0] xs_q
);
  logic          xs_en;
  logic [SW-1:0] xs_d;

  always_comb begin
    xs_en = load || clr;
    xs_d  = load ? load_val : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     xs_q <= '0;
    else if (xs_en) xs_q <= xs_d;
  end
endmodule

// File: rtl/cmp_crf_unit.sv
module cmp_crf_unit
  import cmpu_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_valid,
  input  logic [1:0]          op_kind,
  input  logic                cmp_signed,
  input  logic                use_imm,
  input  logic [XLEN-1:0]     opa,
  input  logic [XLEN-1:0]     opb,
  input  logic [IMMW-1:0]     imm16,
  input  logic [IDXW-1:0]     dst_fld,
  input  logic [IDXW-1:0]     src_fld,
  input  logic                xs_load,
  input  logic [FW-1:0]       xs_load_val,
  output logic [CRW-1:0]      cr_out,
  output logic [FW-1:0]       xs_out
);
  logic            rst_sync_n;
  logic [XLEN-1:0] b_eff;
  logic [2:0]      res_lge;
  logic [FW-1:0]   src_data;
  logic [FW-1:0]   wr_data;
  logic            wr_en;
  logic            xs_clr;
  logic [FW-1:0]   xs_q;
  opk_e            kind;

  cmpu_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  cmpu_operand #(.XLEN(XLEN), .IMMW(IMMW)) u_opnd (
    .reg_b(opb), .imm(imm16), .use_imm(use_imm),
    .is_signed(cmp_signed), .b_eff(b_eff)
  );

  cmpu_compare #(.XLEN(XLEN)) u_cmp (
    .a(opa), .b(b_eff), .is_signed(cmp_signed), .res_lge(res_lge)
  );

  always_comb begin
    kind    = opk_e'(op_kind);
    wr_en   = 1'b0;
    xs_clr  = 1'b0;
    wr_data = '0;
    if (op_valid) begin
      unique case (kind)
        OPK_CMP: begin
          wr_en   = 1'b1;
          wr_data = {res_lge, xs_q[XS_SO]};
        end
        OPK_COPY: begin
          wr_en   = 1'b1;
          wr_data = src_data;
        end
        OPK_XMOVE: begin
          wr_en   = 1'b1;
          xs_clr  = 1'b1;
          wr_data = xs_q;
        end
        default: ;
      endcase
    end
  end

  cmpu_field_file #(.NFIELDS(NFIELDS), .FW(FW)) u_ff (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_idx(dst_fld),
    .wr_data(wr_data), .rd_idx(src_fld), .rd_data(src_data),
    .cr_word(cr_out)
  );

  cmpu_status #(.SW(FW)) u_xs (
    .clk(clk), .rst_n(rst_sync_n), .load(xs_load),
    .load_val(xs_load_val), .clr(xs_clr), .xs_q(xs_q)
  );

  assign xs_out = xs_q;
endmodule

// File: rtl/cmp_crf_unit_chk.sv
module cmp_crf_unit_chk
  import cmpu_pkg::*;
(
  input logic            clk,
  input logic            rst_sync_n,
  input logic            op_valid,
  input logic [1:0]      op_kind,
  input logic [IDXW-1:0] dst_fld,
  input logic [IDXW-1:0] src_fld,
  input logic            xs_load,
  input logic [FW-1:0]   xs_load_val,
  input logic [CRW-1:0]  cr_out,
  input logic [FW-1:0]   xs_out
);
  function automatic logic [FW-1:0] fget(logic [CRW-1:0] cr, logic [IDXW-1:0] i);
    return cr[CRW-1-int'(i)*FW -: FW];
  endfunction

  function automatic logic [CRW-1:0] fmask(logic [IDXW-1:0] i);
    return {{(CRW-FW){1'b0}}, {FW{1'b1}}} << (CRW-FW-int'(i)*FW);
  endfunction

  logic is_cmp, is_copy, is_xmv;
  assign is_cmp  = op_valid && (op_kind == OPK_CMP);
  assign is_copy = op_valid && (op_kind == OPK_COPY);
  assign is_xmv  = op_valid && (op_kind == OPK_XMOVE);

  p_one_outcome_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    is_cmp |=> $countones(fget(cr_out, $past(dst_fld)) >> 1) == 1);

  p_so_fold_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    is_cmp |=> fget(cr_out, $past(dst_fld))[BIT_SO] == $past(xs_out[XS_SO]));

  p_only_dst_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    op_valid |=> ((cr_out ^ $past(cr_out)) & ~fmask($past(dst_fld))) == '0);

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!op_valid || op_kind == OPK_NONE) && !xs_load |=> $stable(cr_out) && $stable(xs_out));

  p_copy_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    is_copy |=> fget(cr_out, $past(dst_fld)) == fget($past(cr_out), $past(src_fld)));

  p_xmove_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    is_xmv && !xs_load |=> xs_out == '0 && fget(cr_out, $past(dst_fld)) == $past(xs_out));

  p_load_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    xs_load |=> xs_out == $past(xs_load_val));
endmodule

bind cmp_crf_unit cmp_crf_unit_chk u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .op_valid(op_valid), .op_kind(op_kind),
  .dst_fld(dst_fld), .src_fld(src_fld), .xs_load(xs_load),
  .xs_load_val(xs_load_val), .cr_out(cr_out), .xs_out(xs_out)
);

// File: tb/sim_cmp_crf_unit.sv
`timescale 1ns/1ps
module sim_cmp_crf_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [1:0]  op_kind;
  logic        cmp_signed, use_imm;
  logic [31:0] opa, opb;
  logic [15:0] imm16;
  logic [2:0]  dst_fld, src_fld;
  logic        xs_load;
  logic [3:0]  xs_load_val;
  logic [31:0] cr_out;
  logic [3:0]  xs_out;

  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;
  logic [31:0] m_cr;
  logic [3:0]  m_xs;

  always #2.5 clk = ~clk;

  cmp_crf_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .cmp_signed(cmp_signed), .use_imm(use_imm), .opa(opa), .opb(opb),
    .imm16(imm16), .dst_fld(dst_fld), .src_fld(src_fld), .xs_load(xs_load),
    .xs_load_val(xs_load_val), .cr_out(cr_out), .xs_out(xs_out)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] fld(logic [31:0] cr, int i);
    return cr[31-4*i -: 4];
  endfunction

  function automatic logic [3:0] model_cmp(logic [31:0] a, logic [31:0] b, logic s, logic so);
    logic lt;
    if (s) lt = $signed(a) < $signed(b);
    else   lt = a < b;
    if (a == b) return {3'b001, so};
    else if (lt) return {3'b100, so};
    else return {3'b010, so};
  endfunction

  task automatic idle_inputs();
    op_valid = 0; op_kind = 2'd3; cmp_signed = 0; use_imm = 0;
    opa = '0; opb = '0; imm16 = '0; dst_fld = '0; src_fld = '0;
    xs_load = 0; xs_load_val = '0;
  endtask

  // drive one operation at a falling edge, let one rising edge pass, check at next falling edge
  task automatic apply(string tag, logic v, logic [1:0] k, logic s, logic ui,
                       logic [31:0] a, logic [31:0] b, logic [15:0] im,
                       logic [2:0] d, logic [2:0] sr, logic ld, logic [3:0] ldv);
    logic [31:0] be;
    logic [3:0]  w;
    logic [3:0]  old_xs;
    @(negedge clk);
    op_valid = v; op_kind = k; cmp_signed = s; use_imm = ui; opa = a; opb = b;
    imm16 = im; dst_fld = d; src_fld = sr; xs_load = ld; xs_load_val = ldv;
    old_xs = m_xs;
    be = ui ? (s ? {{16{im[15]}}, im} : {16'h0, im}) : b;
    if (v) begin
      case (k)
        2'd0: begin w = model_cmp(a, be, s, old_xs[3]); m_cr[31-4*d -: 4] = w; end
        2'd1: begin w = fld(m_cr, sr); m_cr[31-4*d -: 4] = w; end
        2'd2: begin m_cr[31-4*d -: 4] = old_xs; m_xs = 4'h0; end
        default: ;
      endcase
    end
    if (ld) m_xs = ldv;
    @(negedge clk);
    idle_inputs();
    chk({tag, " cr"}, cr_out, m_cr);
    chk({tag, " xs"}, {28'h0, xs_out}, {28'h0, m_xs});
  endtask

  task automatic t_reset();
    rst_n = 0;
    idle_inputs();
    repeat (3) @(negedge clk);
    chk("R1 cr in reset", cr_out, 32'h0);
    chk("R1 xs in reset", {28'h0, xs_out}, 32'h0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 cr after release", cr_out, 32'h0);
    chk("R1 xs after release", {28'h0, xs_out}, 32'h0);
    m_cr = '0; m_xs = '0;
  endtask

  task automatic t_signed_reg();
    apply("R2 -5 vs 3 signed field2", 1, 2'd0, 1, 0, 32'hFFFF_FFFB, 32'd3, 16'h0, 3'd2, 3'd0, 0, 4'h0);
    chk("R7 field2 nibble", {28'h0, fld(cr_out, 2)}, 32'h8);
    apply("R2 100 vs -100 signed field6", 1, 2'd0, 1, 0, 32'd100, 32'hFFFF_FF9C, 16'h0, 3'd6, 3'd0, 0, 4'h0);
    apply("R2 equal field7", 1, 2'd0, 1, 0, 32'h1234, 32'h1234, 16'h0, 3'd7, 3'd0, 0, 4'h0);
    chk("R7 field7 nibble low", {28'h0, cr_out[3:0]}, 32'h2);
  endtask

  task automatic t_unsigned_reg();
    apply("R3 FFFFFFFB vs 3 unsigned field5", 1, 2'd0, 0, 0, 32'hFFFF_FFFB, 32'd3, 16'h0, 3'd5, 3'd0, 0, 4'h0);
    apply("R3 7FFFFFFF vs 80000000 unsigned field3", 1, 2'd0, 0, 0, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0, 3'd3, 3'd0, 0, 4'h0);
  endtask

  task automatic t_imm();
    apply("R4 -1 vs imm FFFF signed", 1, 2'd0, 1, 1, 32'hFFFF_FFFF, 32'h0, 16'hFFFF, 3'd1, 3'd0, 0, 4'h0);
    apply("R4 1 vs imm 8000 signed, opb ignored", 1, 2'd0, 1, 1, 32'd1, 32'h7FFF_FFFF, 16'h8000, 3'd4, 3'd0, 0, 4'h0);
    apply("R5 FFFFFFFF vs imm FFFF unsigned", 1, 2'd0, 0, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 3'd0, 3'd0, 0, 4'h0);
    apply("R5 0000FFFF vs imm FFFF unsigned", 1, 2'd0, 0, 1, 32'h0000_FFFF, 32'h0, 16'hFFFF, 3'd6, 3'd0, 0, 4'h0);
  endtask

  task automatic t_so_fold();
    apply("R11 load SO", 0, 2'd0, 0, 0, 32'h0, 32'h0, 16'h0, 3'd0, 3'd0, 1, 4'b1000);
    apply("R6 compare with SO set", 1, 2'd0, 0, 0, 32'd9, 32'd4, 16'h0, 3'd2, 3'd0, 0, 4'h0);
    chk("R6 field2 bit0", {31'h0, cr_out[20]}, 32'h1);
  endtask

  task automatic t_copy();
    apply("R9 copy field2 to field0", 1, 2'd1, 0, 0, 32'h0, 32'h0, 16'h0, 3'd0, 3'd2, 0, 4'h0);
    apply("R9 copy field7 to field3", 1, 2'd1, 0, 0, 32'h0, 32'h0, 16'h0, 3'd3, 3'd7, 0, 4'h0);
  endtask

  task automatic t_xmove();
    apply("R11 load 1110", 0, 2'd0, 0, 0, 32'h0, 32'h0, 16'h0, 3'd0, 3'd0, 1, 4'b1110);
    apply("R10 move status to field4", 1, 2'd2, 0, 0, 32'h0, 32'h0, 16'h0, 3'd4, 3'd0, 0, 4'h0);
    chk("R10 field4 nibble", {28'h0, fld(cr_out, 4)}, 32'hE);
    apply("R11 load 0111", 0, 2'd0, 0, 0, 32'h0, 32'h0, 16'h0, 3'd0, 3'd0, 1, 4'b0111);
    apply("R11 load beats move clear", 1, 2'd2, 0, 0, 32'h0, 32'h0, 16'h0, 3'd5, 3'd0, 1, 4'b0101);
  endtask

  task automatic t_idle();
    apply("R8 valid low ignored", 0, 2'd0, 1, 0, 32'd1, 32'd2, 16'h0, 3'd1, 3'd0, 0, 4'h0);
    apply("R8 op_kind 3 ignored", 1, 2'd3, 1, 0, 32'd1, 32'd2, 16'h0, 3'd1, 3'd0, 0, 4'h0);
  endtask

  initial begin
    idle_inputs();
    t_reset();
    t_signed_reg();
    t_unsigned_reg();
    t_imm();
    t_so_fold();
    t_copy();
    t_xmove();
    t_idle();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule